// File: doc/BRIEF.md
# Fused multiply-add align, add and normalize stage

This block is the mantissa datapath of a double-precision fused multiply-add unit. It sits after operand classification and special-value handling, and after the 53x53 multiplier. The multiplier hands over the product as a sign, an unbiased exponent and a 128-bit magnitude. The leading one of that magnitude sits at bit 126 or bit 127. The addend arrives as a sign, an unbiased exponent and a 53-bit mantissa that includes the hidden bit. A flag marks a zero addend, and a rounding-mode bit selects round toward minus infinity.

The block brings the two magnitudes to a common exponent inside a 128-bit field, without losing any shifted-out bits. It then adds the magnitudes, or subtracts the smaller from the larger, and normalizes the result so that the leading one lands at bit 126. Finally it reduces the result to a 56-bit mantissa: 53 significant bits followed by guard, round and sticky. A downstream rounder and packer consume this mantissa.

The work is split into two registered stages behind a valid/ready handshake. The first stage aligns the operands. The second stage adds and normalizes.

Top module: `fma_align_norm`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When bit 127 of `prod_man` is set, the product is shifted right by one before use, the bit shifted out is ORed into bit 0, and the product exponent is raised by one.
- R3: The addend is placed with its hidden bit (bit 52) at bit 126 and zeros below. The operand with the smaller exponent is shifted right by the exponent difference, and every bit shifted out is ORed into bit 0. A difference of 128 or more leaves only that OR in bit 0. The larger exponent becomes the common exponent.
- R4: When the signs match, the aligned magnitudes are added. A carry into bit 127 shifts the sum right by one, folds the lost bit into bit 0, and raises the exponent by one.
- R5: When the signs differ, the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger one.
- R6: When the aligned magnitudes cancel exactly, `res_man` is 0 and `res_exp` is 0. `res_sign` equals `round_down`, where 1 selects round toward minus infinity.
- R7: After a subtraction, the difference is shifted left until its leading one is at bit 126, and the exponent is lowered by the same amount.
- R8: `res_man[55:1]` holds bits 126 down to 72 of the final 128-bit value. `res_man[0]` is the OR of bits 71 down to 0. A nonzero result therefore has `res_man[55]` set.
- R9: When `add_zero` is 1, the addend fields are ignored. The result is the product alone, after the R2 step, with the product sign and exponent.
- R10: An input accepted at a clock edge with the output path free appears on `out_valid` after the second following edge. `in_ready` drops only when both stages hold data and `out_ready` is 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output valid and all result fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can take an operand set |
| prod_sign | input | 1 | Product sign, already negated for a subtracting operation |
| prod_exp | input | 14 | Product exponent, signed, unbiased |
| prod_man | input | 128 | Product magnitude, leading one at bit 126 or 127 |
| add_sign | input | 1 | Addend sign |
| add_exp | input | 14 | Addend exponent, signed, unbiased |
| add_man | input | 53 | Addend mantissa with the hidden bit at bit 52 |
| add_zero | input | 1 | Addend is zero |
| round_down | input | 1 | Rounding mode is toward minus infinity |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | 14 | Result exponent, signed, unbiased |
| res_man | output | 56 | Result mantissa: hidden bit at bit 55, sticky at bit 0 |

## Verification
Two things can happen in the same cycle: a stalled second stage holds its result while the first stage captures a new operand set. The bench provokes this by lowering `out_ready` and offering two operand sets back to back. It then expects `in_ready` to fall, expects the first result to stay unchanged over several cycles, and expects the second result, computed by hand, to appear one edge after `out_ready` returns. A second overlap happens inside the adder stage, where a carry renormalization and sticky folding occur together. One vector sums two operands whose low bit would otherwise be lost, and the bench expects bit 0 of the mantissa to be set.

// File: rtl/fma_an_pkg.sv
package fma_an_pkg;
  localparam int PROD_W = 128;
  localparam int ADD_W  = 53;
  localparam int RES_W  = 56;
  localparam int EXP_W  = 14;

  typedef enum logic [1:0] {
    PATH_PROD_ONLY = 2'd0,
    PATH_ADD       = 2'd1,
    PATH_SUB       = 2'd2
  } path_e;
endpackage

// File: rtl/sticky_shr.sv
// Right shift that ORs every discarded bit into bit 0 of the result.
module sticky_shr #(
  parameter int W  = 128,
  parameter int SW = 8,
  parameter int OW = 128
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] amt,
  output logic [OW-1:0] q
);
  always_comb begin
    q = '0;
    if (int'(amt) >= W) begin
      q[0] = |d;
    end else begin
      q    = OW'(d >> amt);
      q[0] = q[0] | (|(d & ~({W{1'b1}} << amt)));
    end
  end
endmodule

// File: rtl/lead_zero_cnt.sv
// Priority count of zeros above the most significant set bit.
module lead_zero_cnt #(
  parameter int W  = 128,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fma_align_norm.sv
module fma_align_norm
  import fma_an_pkg::*;
#(
  parameter int PW = PROD_W,
  parameter int AW = ADD_W,
  parameter int RW = RES_W,
  parameter int EW = EXP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 prod_sign,
  input  logic signed [EW-1:0] prod_exp,
  input  logic [PW-1:0]        prod_man,
  input  logic                 add_sign,
  input  logic signed [EW-1:0] add_exp,
  input  logic [AW-1:0]        add_man,
  input  logic                 add_zero,
  input  logic                 round_down,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 res_sign,
  output logic signed [EW-1:0] res_exp,
  output logic [RW-1:0]        res_man
);
  localparam int LEAD   = PW - 2;
  localparam int ADD_SH = LEAD - (AW - 1);
  localparam int OUT_SH = LEAD - (RW - 1);
  localparam int TOP_Z  = PW - AW - ADD_SH;
  localparam int SW     = $clog2(PW) + 1;
  localparam int CW     = $clog2(PW + 1);

  // ---------------- handshake ----------------
  logic s1_v;
  logic adv2, take1;
  assign adv2     = !out_valid || out_ready;
  assign in_ready = !s1_v || adv2;
  assign take1    = in_valid && in_ready;

  // ---------------- stage 1: prenormalize and align ----------------
  logic [PW-1:0]        pn_man, z_place, shift_src, shifted;
  logic signed [EW-1:0] pn_exp;
  logic signed [EW:0]   d_exp;
  logic [EW:0]          d_abs;
  logic [SW-1:0]        amt;
  logic                 z_bigger;

  always_comb begin
    if (prod_man[PW-1]) begin
      pn_man = {1'b0, prod_man[PW-1:2], prod_man[1] | prod_man[0]};
      pn_exp = prod_exp + EW'(1);
    end else begin
      pn_man = prod_man;
      pn_exp = prod_exp;
    end
    z_place   = {{TOP_Z{1'b0}}, add_man, {ADD_SH{1'b0}}};
    d_exp     = {add_exp[EW-1], add_exp} - {pn_exp[EW-1], pn_exp};
    z_bigger  = d_exp > 0;
    d_abs     = z_bigger ? d_exp : -d_exp;
    amt       = (d_abs >= (EW+1)'(PW)) ? SW'(PW) : d_abs[SW-1:0];
    shift_src = z_bigger ? pn_man : z_place;
  end

  sticky_shr #(.W(PW), .SW(SW), .OW(PW)) u_align (
    .d  (shift_src),
    .amt(amt),
    .q  (shifted)
  );

  path_e                s1_path;
  logic [PW-1:0]        s1_pm, s1_zm;
  logic signed [EW-1:0] s1_exp;
  logic                 s1_ps, s1_zs, s1_rd;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else if (in_ready) s1_v <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take1) begin
      s1_ps <= prod_sign;
      s1_zs <= add_sign;
      s1_rd <= round_down;
      if (add_zero) begin
        s1_path <= PATH_PROD_ONLY;
        s1_pm   <= pn_man;
        s1_zm   <= '0;
        s1_exp  <= pn_exp;
      end else begin
        s1_path <= (prod_sign == add_sign) ? PATH_ADD : PATH_SUB;
        s1_pm   <= z_bigger ? shifted : pn_man;
        s1_zm   <= z_bigger ? z_place : shifted;
        s1_exp  <= z_bigger ? add_exp : pn_exp;
      end
    end
  end

  // ---------------- stage 2: add, normalize, reduce ----------------
  logic [PW-1:0]        sum, dif, mag, fin_src;
  logic                 z_ge;
  logic [CW-1:0]        lz;
  logic [CW-1:0]        nsh;
  logic signed [EW-1:0] r_exp;
  logic                 r_sign, r_zero;
  logic [RW-1:0]        fin;

  lead_zero_cnt #(.W(PW), .CW(CW)) u_lzc (
    .d  (dif),
    .cnt(lz)
  );

  always_comb begin
    sum    = s1_pm + s1_zm;
    z_ge   = s1_zm >= s1_pm;
    dif    = z_ge ? (s1_zm - s1_pm) : (s1_pm - s1_zm);
    nsh    = lz - CW'(1);
    mag    = s1_pm;
    r_exp  = s1_exp;
    r_sign = s1_ps;
    r_zero = 1'b0;
    unique case (s1_path)
      PATH_ADD: begin
        if (sum[PW-1]) begin
          mag   = {1'b0, sum[PW-1:2], sum[1] | sum[0]};
          r_exp = s1_exp + EW'(1);
        end else begin
          mag = sum;
        end
      end
      PATH_SUB: begin
        if (dif == '0) begin
          r_zero = 1'b1;
          r_sign = s1_rd;
        end else begin
          mag    = dif << nsh;
          r_exp  = s1_exp - EW'(nsh);
          r_sign = z_ge ? s1_zs : s1_ps;
        end
      end
      default: ;
    endcase
    fin_src = mag;
  end

  sticky_shr #(.W(PW), .SW(SW), .OW(RW)) u_reduce (
    .d  (fin_src),
    .amt(SW'(OUT_SH)),
    .q  (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv2) out_valid <= s1_v;
  end

  always_ff @(posedge clk) begin
    if (adv2 && s1_v) begin
      res_sign <= r_sign;
      res_exp  <= r_zero ? '0 : r_exp;
      res_man  <= r_zero ? '0 : fin;
    end
  end
endmodule

// File: rtl/fma_an_chk.sv
module fma_an_chk #(
  parameter int RW = 56,
  parameter int EW = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 res_sign,
  input logic signed [EW-1:0] res_exp,
  input logic [RW-1:0]        res_man
);
  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);

  assert_hold_data_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(res_man) && $stable(res_exp) && $stable(res_sign));

  assert_stall_full_R10: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid && !out_ready);

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  assert_hidden_bit_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && res_man != '0 |-> res_man[RW-1]);

  assert_zero_exp_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && res_man == '0 |-> res_exp == '0);
endmodule

bind fma_align_norm fma_an_chk #(.RW(RW), .EW(EW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .res_sign (res_sign),
  .res_exp  (res_exp),
  .res_man  (res_man)
);

// File: tb/sim_fma_align_norm.sv
`timescale 1ns/1ps
module sim_fma_align_norm;
  localparam int NV = 12;
  localparam logic [127:0] P1 = 128'd1 << 126;
  localparam logic [52:0]  Z1 = 53'd1 << 52;
  localparam logic [55:0]  M1 = 56'd1 << 55;

  typedef struct packed {
    logic               ps;
    logic signed [13:0] pe;
    logic [127:0]       pm;
    logic               zs;
    logic signed [13:0] ze;
    logic [52:0]        zm;
    logic               zz;
    logic               rd;
    logic               es;
    logic signed [13:0] ee;
    logic [55:0]        em;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0, 14'sd0, P1, 1'b0, 14'sd0, Z1, 1'b0, 1'b0, 1'b0, 14'sd1, M1},                             // R4 carry
    '{1'b0, 14'sd0, P1, 1'b0, 14'sd2, Z1, 1'b0, 1'b0, 1'b0, 14'sd2, M1 | (56'd1 << 53)},             // R3 product shifted
    '{1'b0, 14'sd0, P1, 1'b1, 14'sd0, Z1, 1'b0, 1'b0, 1'b0, 14'sd0, 56'd0},                          // R6 cancel, nearest
    '{1'b0, 14'sd0, P1, 1'b1, 14'sd0, Z1, 1'b0, 1'b1, 1'b1, 14'sd0, 56'd0},                          // R6 cancel, down
    '{1'b0, 14'sd0, P1, 1'b1, 14'sd0, 53'd3 << 51, 1'b0, 1'b0, 1'b1, -14'sd1, M1},                    // R5 R7
    '{1'b1, 14'sd5, P1 | (128'd1 << 72) | 128'd1, 1'b0, 14'sd100, Z1, 1'b1, 1'b0, 1'b1, 14'sd5, M1 | 56'd3}, // R9 R8
    '{1'b0, 14'sd3, (128'd1 << 127) | 128'd1, 1'b0, 14'sd0, Z1, 1'b1, 1'b0, 1'b0, 14'sd4, M1 | 56'd1},   // R2
    '{1'b0, 14'sd0, P1, 1'b0, 14'sd200, Z1, 1'b0, 1'b0, 1'b0, 14'sd200, M1 | 56'd1},                  // R3 huge shift
    '{1'b0, 14'sd0, P1, 1'b1, 14'sd1, Z1, 1'b0, 1'b0, 1'b1, 14'sd0, M1},                             // R5 R7
    '{1'b0, 14'sd3, P1, 1'b0, 14'sd0, Z1, 1'b0, 1'b0, 1'b0, 14'sd3, M1 | (56'd1 << 52)},             // R3 addend shifted
    '{1'b0, 14'sd0, P1 | (128'd1 << 74), 1'b1, 14'sd0, Z1, 1'b0, 1'b0, 1'b0, -14'sd52, M1},           // R7 deep cancel
    '{1'b0, 14'sd0, P1 | 128'd1, 1'b0, 14'sd0, Z1, 1'b0, 1'b0, 1'b0, 14'sd1, M1 | 56'd1}             // R4 carry sticky
  };

  function automatic string tag_of(int i);
    case (i)
      0: tag_of = "R4";  1: tag_of = "R3";  2: tag_of = "R6";  3: tag_of = "R6";
      4: tag_of = "R5";  5: tag_of = "R9";  6: tag_of = "R2";  7: tag_of = "R3";
      8: tag_of = "R7";  9: tag_of = "R3"; 10: tag_of = "R7";  default: tag_of = "R4";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic prod_sign = 1'b0, add_sign = 1'b0, add_zero = 1'b0, round_down = 1'b0;
  logic signed [13:0] prod_exp = '0, add_exp = '0;
  logic [127:0] prod_man = '0;
  logic [52:0]  add_man = '0;
  logic out_valid, out_ready = 1'b1, res_sign;
  logic signed [13:0] res_exp;
  logic [55:0] res_man;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fma_align_norm u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .prod_sign(prod_sign), .prod_exp(prod_exp), .prod_man(prod_man),
    .add_sign(add_sign), .add_exp(add_exp), .add_man(add_man),
    .add_zero(add_zero), .round_down(round_down),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_sign(res_sign), .res_exp(res_exp), .res_man(res_man)
  );

  task automatic drive(input vec_t v);
    prod_sign  = v.ps; prod_exp = v.pe; prod_man = v.pm;
    add_sign   = v.zs; add_exp  = v.ze; add_man  = v.zm;
    add_zero   = v.zz; round_down = v.rd;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  task automatic check_res(input string req, input vec_t v);
    checks++;
    if (out_valid !== 1'b1 || res_sign !== v.es || res_exp !== v.ee || res_man !== v.em) begin
      failures++;
      $display("FAIL %s actual=v%b s%b e%0d m%h expected=v1 s%b e%0d m%h",
               req, out_valid, res_sign, res_exp, res_man, v.es, v.ee, v.em);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid in reset", out_valid, 1'b0);
    check_bit("R1 in_ready in reset", in_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (i == 0) check_bit("R10 not yet valid after one edge", out_valid, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_res(tag_of(i), TBL[i]);
    end

    // backpressure with a second operand set captured behind it
    @(negedge clk);
    out_ready = 1'b0;
    drive(TBL[0]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(TBL[9]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10 in_ready low when full", in_ready, 1'b0);
    check_res("R11 first result shown", TBL[0]);
    repeat (3) @(negedge clk);
    check_res("R11 first result held", TBL[0]);
    out_ready = 1'b1;
    @(negedge clk);
    check_res("R11 second result after release", TBL[9]);
    @(negedge clk);
    check_bit("R10 drained", out_valid, 1'b0);
    check_bit("R10 in_ready back", in_ready, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule